// File: doc/BRIEF.md
# Instruction Decoder with Program Counter Update

This block takes one 32-bit instruction word together with the current program counter, splits the word into its fields and classifies it. It also owns the program counter register. Three layouts are recognised. The register layout is picked by one reserved primary opcode, and a secondary function field inside the word then selects the operation. The immediate layout carries a 16-bit signed constant. The jump layout carries a 26-bit word index and is used only by the call.

Each cycle with the advance strobe high, the counter takes its next value. That value is one of three:

- the following word, which is the default;
- a PC-relative target, when the instruction is a conditional branch and the external comparator reports the branch as taken;
- a call target built from the current region bits and the 26-bit index.

The link address (counter plus four) is always present on an output so a call can save it. Words the decoder does not know raise an illegal flag and move the counter to the next word.

Top module: `insn_decode_pc`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, pc equals RESET_PC (default 0).
- R2: When advance is low at a rising clock edge, pc keeps its value.
- R3: With advance high, every instruction that is not a call and not a taken branch loads pc with pc+4. This includes illegal words.
- R4: The branch opcode is 0x16 in bits [5:0]. With advance and br_taken high, pc becomes pc+4+SE(bits[21:6]) with bits [1:0] of the result cleared. With br_taken low, pc becomes pc+4.
- R5: br_taken has no effect on the next pc for any instruction other than the branch.
- R6: The call opcode is 0x00. With advance high, a call loads pc with {pc[31:28], bits[31:6], 2'b00}. link_addr always equals pc+4.
- R7: fmt encodes the layout as follows: 1 for opcode 0x3A, 2 for opcode 0x00, 0 for opcodes 0x04, 0x16 and 0x17, and 3 for any other opcode.
- R8: The field outputs are fld_a = bits[31:27], fld_b = bits[26:22], fld_c = bits[21:17], fn_code = bits[16:11], sh_amt = bits[10:6] and imm_long = bits[31:6].
- R9: imm_sx is bits[21:6] sign-extended from bit 21.
- R10: illegal is high for any opcode outside {0x00, 0x04, 0x16, 0x17, 0x3A}. It is also high for opcode 0x3A when fn_code is neither 0x31 nor 0x39. While illegal is high, every class flag is low.
- R11: The class flags are as follows. is_alu is high for opcode 0x04 and for 0x3A with fn_code 0x31 or 0x39. alu_sub is high only for fn_code 0x39 under opcode 0x3A. is_load is high for opcode 0x17, is_branch for 0x16 and is_call for 0x00. At most one of is_alu, is_load, is_branch and is_call is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| advance | input | 1 | Enables the pc update |
| br_taken | input | 1 | Comparator result for the branch |
| pc | output | XLEN | Program counter |
| fmt | output | 2 | Layout code |
| fld_a | output | 5 | First register index |
| fld_b | output | 5 | Second register index |
| fld_c | output | 5 | Third register index (register layout) |
| fn_code | output | 6 | Function field (register layout) |
| sh_amt | output | 5 | 5-bit immediate (register layout) |
| imm_sx | output | XLEN | Sign-extended 16-bit immediate |
| imm_long | output | 26 | 26-bit call index |
| is_alu | output | 1 | Arithmetic instruction |
| alu_sub | output | 1 | Subtract selected |
| is_load | output | 1 | Word load |
| is_branch | output | 1 | Conditional branch |
| is_call | output | 1 | Call |
| illegal | output | 1 | Unknown opcode or function |
| link_addr | output | XLEN | Return address, pc+4 |

## Verification
The bench builds the block with its default parameters: XLEN of 32 and RESET_PC of 0. These defaults leave four region bits above the 26-bit call index. A taken branch with a negative offset from address 0 wraps pc into the top region, so the bench can check that a later call keeps those region bits. Random words are mixed across every opcode and across both legal and illegal function codes. Directed cases cover branch offsets that are not word aligned and taken strobes presented to non-branch instructions.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int IW     = 32;
  localparam int RW     = 5;
  localparam int OPW    = 6;
  localparam int FNW    = 6;
  localparam int IMM_W  = 16;
  localparam int LONG_W = 26;

  typedef enum logic [1:0] {
    FMT_IMM = 2'd0,
    FMT_REG = 2'd1,
    FMT_JMP = 2'd2,
    FMT_BAD = 2'd3
  } fmt_e;

  localparam logic [OPW-1:0] OP_CALL = 6'h00;
  localparam logic [OPW-1:0] OP_ADDI = 6'h04;
  localparam logic [OPW-1:0] OP_BLT  = 6'h16;
  localparam logic [OPW-1:0] OP_LDW  = 6'h17;
  localparam logic [OPW-1:0] OP_REG  = 6'h3A;
  localparam logic [FNW-1:0] FN_ADD  = 6'h31;
  localparam logic [FNW-1:0] FN_SUB  = 6'h39;

  typedef struct packed {
    logic is_alu;
    logic alu_sub;
    logic is_load;
    logic is_branch;
    logic is_call;
    logic illegal;
  } kind_t;
endpackage

// File: rtl/insn_field_split.sv
module insn_field_split
  import insn_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [IW-1:0]     instr,
  output logic [OPW-1:0]    op,
  output logic [RW-1:0]     fa,
  output logic [RW-1:0]     fb,
  output logic [RW-1:0]     fc,
  output logic [FNW-1:0]    fn,
  output logic [RW-1:0]     sh,
  output logic [XLEN-1:0]   imm_sx,
  output logic [LONG_W-1:0] imm_long
);
  localparam int A_LSB   = IW - RW;
  localparam int B_LSB   = A_LSB - RW;
  localparam int C_LSB   = B_LSB - RW;
  localparam int SH_LSB  = OPW;
  localparam int FN_LSB  = SH_LSB + RW;
  localparam int IMM_LSB = OPW;
  localparam int IMM_MSB = IMM_LSB + IMM_W - 1;

  always_comb begin
    op       = instr[OPW-1:0];
    fa       = instr[A_LSB +: RW];
    fb       = instr[B_LSB +: RW];
    fc       = instr[C_LSB +: RW];
    fn       = instr[FN_LSB +: FNW];
    sh       = instr[SH_LSB +: RW];
    imm_sx   = {{(XLEN-IMM_W){instr[IMM_MSB]}}, instr[IMM_LSB +: IMM_W]};
    imm_long = instr[OPW +: LONG_W];
  end
endmodule

// File: rtl/insn_classifier.sv
module insn_classifier
  import insn_dec_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [FNW-1:0] fn,
  output fmt_e           fmt,
  output kind_t          kind
);
  always_comb begin
    fmt  = FMT_BAD;
    kind = '0;
    unique case (op)
      OP_CALL: begin fmt = FMT_JMP; kind.is_call   = 1'b1; end
      OP_ADDI: begin fmt = FMT_IMM; kind.is_alu    = 1'b1; end
      OP_BLT:  begin fmt = FMT_IMM; kind.is_branch = 1'b1; end
      OP_LDW:  begin fmt = FMT_IMM; kind.is_load   = 1'b1; end
      OP_REG: begin
        fmt = FMT_REG;
        if (fn == FN_ADD) begin
          kind.is_alu = 1'b1;
        end else if (fn == FN_SUB) begin
          kind.is_alu  = 1'b1;
          kind.alu_sub = 1'b1;
        end else begin
          kind.illegal = 1'b1;
        end
      end
      default: kind.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import insn_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   imm_sx,
  input  logic [LONG_W-1:0] imm_long,
  input  kind_t             kind,
  input  logic              br_taken,
  output logic [XLEN-1:0]   nxt_pc,
  output logic [XLEN-1:0]   link
);
  localparam int REGION = XLEN - LONG_W - 2;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_sum;
  logic [XLEN-1:0] call_pc;

  generate
    if (REGION > 0) begin : g_region
      always_comb call_pc = {pc[XLEN-1 -: REGION], imm_long, 2'b00};
    end else begin : g_flat
      logic [LONG_W+1:0] full_tgt;
      always_comb full_tgt = {imm_long, 2'b00};
      always_comb call_pc  = full_tgt[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    seq_pc = pc + XLEN'(4);
    br_sum = seq_pc + imm_sx;
    link   = seq_pc;
    if (kind.is_call) begin
      nxt_pc = call_pc;
    end else if (kind.is_branch && br_taken) begin
      nxt_pc = {br_sum[XLEN-1:2], 2'b00};
    end else begin
      nxt_pc = seq_pc;
    end
  end
endmodule

// File: rtl/insn_decode_pc.sv
module insn_decode_pc
  import insn_dec_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr,
  input  logic              advance,
  input  logic              br_taken,
  output logic [XLEN-1:0]   pc,
  output logic [1:0]        fmt,
  output logic [4:0]        fld_a,
  output logic [4:0]        fld_b,
  output logic [4:0]        fld_c,
  output logic [5:0]        fn_code,
  output logic [4:0]        sh_amt,
  output logic [XLEN-1:0]   imm_sx,
  output logic [25:0]       imm_long,
  output logic              is_alu,
  output logic              alu_sub,
  output logic              is_load,
  output logic              is_branch,
  output logic              is_call,
  output logic              illegal,
  output logic [XLEN-1:0]   link_addr
);
  logic [OPW-1:0]  op;
  fmt_e            fmt_w;
  kind_t           kind;
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;

  insn_field_split #(.XLEN(XLEN)) u_split (
    .instr    (instr),
    .op       (op),
    .fa       (fld_a),
    .fb       (fld_b),
    .fc       (fld_c),
    .fn       (fn_code),
    .sh       (sh_amt),
    .imm_sx   (imm_sx),
    .imm_long (imm_long)
  );

  insn_classifier u_class (
    .op   (op),
    .fn   (fn_code),
    .fmt  (fmt_w),
    .kind (kind)
  );

  pc_next_unit #(.XLEN(XLEN)) u_next (
    .pc       (pc_q),
    .imm_sx   (imm_sx),
    .imm_long (imm_long),
    .kind     (kind),
    .br_taken (br_taken),
    .nxt_pc   (pc_d),
    .link     (link_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else if (advance) begin
      pc_q <= pc_d;
    end
  end

  always_comb begin
    pc        = pc_q;
    fmt       = fmt_w;
    is_alu    = kind.is_alu;
    alu_sub   = kind.alu_sub;
    is_load   = kind.is_load;
    is_branch = kind.is_branch;
    is_call   = kind.is_call;
    illegal   = kind.illegal;
  end
endmodule

// File: rtl/insn_decode_pc_chk.sv
module insn_decode_pc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:0]     instr,
  input logic            advance,
  input logic            br_taken,
  input logic [XLEN-1:0] pc,
  input logic            is_alu,
  input logic            is_load,
  input logic            is_branch,
  input logic            is_call,
  input logic            illegal,
  input logic [XLEN-1:0] link_addr
);
  // R2
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> pc == $past(pc));

  // R3
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !is_call && !is_branch) |=> pc == $past(pc) + XLEN'(4));

  // R4
  a_r4_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && is_branch && !br_taken) |=> pc == $past(pc) + XLEN'(4));

  // R6
  a_r6_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && is_call) |=> (pc[XLEN-1:28] == $past(pc[XLEN-1:28]))
                         && (pc[27:0] == {$past(instr[31:6]), 2'b00}));

  // R6
  a_r6_link_next: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !is_call && !is_branch) |=> pc == $past(link_addr));

  // R10
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !(is_alu || is_load || is_branch || is_call));

  // R11
  a_r11_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_alu, is_load, is_branch, is_call}));

  // R4
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
endmodule

bind insn_decode_pc insn_decode_pc_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .instr     (instr),
  .advance   (advance),
  .br_taken  (br_taken),
  .pc        (pc),
  .is_alu    (is_alu),
  .is_load   (is_load),
  .is_branch (is_branch),
  .is_call   (is_call),
  .illegal   (illegal),
  .link_addr (link_addr)
);

// File: tb/sim_insn_decode_pc.sv
`timescale 1ns/1ps
module sim_insn_decode_pc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr;
  logic        advance;
  logic        br_taken;
  logic [31:0] pc;
  logic [1:0]  fmt;
  logic [4:0]  fld_a, fld_b, fld_c, sh_amt;
  logic [5:0]  fn_code;
  logic [31:0] imm_sx;
  logic [25:0] imm_long;
  logic        is_alu, alu_sub, is_load, is_branch, is_call, illegal;
  logic [31:0] link_addr;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_pc;

  always #5 clk = ~clk;

  insn_decode_pc u0 (
    .clk(clk), .rst_n(rst_n), .instr(instr), .advance(advance),
    .br_taken(br_taken), .pc(pc), .fmt(fmt), .fld_a(fld_a), .fld_b(fld_b),
    .fld_c(fld_c), .fn_code(fn_code), .sh_amt(sh_amt), .imm_sx(imm_sx),
    .imm_long(imm_long), .is_alu(is_alu), .alu_sub(alu_sub),
    .is_load(is_load), .is_branch(is_branch), .is_call(is_call),
    .illegal(illegal), .link_addr(link_addr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_fmt(input logic [31:0] w);
    case (w[5:0])
      6'h00: return 2'd2;
      6'h3A: return 2'd1;
      6'h04, 6'h16, 6'h17: return 2'd0;
      default: return 2'd3;
    endcase
  endfunction

  // {is_alu, alu_sub, is_load, is_branch, is_call, illegal}
  function automatic logic [5:0] ref_flags(input logic [31:0] w);
    case (w[5:0])
      6'h00: return 6'b000010;
      6'h04: return 6'b100000;
      6'h16: return 6'b000100;
      6'h17: return 6'b001000;
      6'h3A: begin
        if (w[16:11] == 6'h31) return 6'b100000;
        if (w[16:11] == 6'h39) return 6'b110000;
        return 6'b000001;
      end
      default: return 6'b000001;
    endcase
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] w,
                                           input logic adv, input logic tk);
    logic [31:0] s;
    if (!adv) return p;
    if (w[5:0] == 6'h00) return {p[31:28], w[31:6], 2'b00};
    if (w[5:0] == 6'h16 && tk) begin
      s = p + 32'd4 + {{16{w[21]}}, w[21:6]};
      return {s[31:2], 2'b00};
    end
    return p + 32'd4;
  endfunction

  task automatic step(input logic [31:0] w, input logic adv, input logic tk);
    @(negedge clk);
    instr = w; advance = adv; br_taken = tk;
    #1;
    chk("R7 fmt", 64'(fmt), 64'(ref_fmt(w)));
    chk("R8 fields", {fld_a, fld_b, fld_c, fn_code, sh_amt},
        {w[31:27], w[26:22], w[21:17], w[16:11], w[10:6]});
    chk("R8 imm_long", 64'(imm_long), 64'(w[31:6]));
    chk("R9 imm_sx", 64'(imm_sx), 64'({{16{w[21]}}, w[21:6]}));
    chk("R10 R11 flags", 64'({is_alu, alu_sub, is_load, is_branch, is_call, illegal}),
        64'(ref_flags(w)));
    chk("R6 link", 64'(link_addr), 64'(exp_pc + 32'd4));
    exp_pc = ref_next(exp_pc, w, adv, tk);
    @(posedge clk);
    #1;
    if (!adv)                 chk("R2 hold", 64'(pc), 64'(exp_pc));
    else if (w[5:0] == 6'h00) chk("R6 call", 64'(pc), 64'(exp_pc));
    else if (w[5:0] == 6'h16) chk("R4 branch", 64'(pc), 64'(exp_pc));
    else if (tk)              chk("R5 taken ignored", 64'(pc), 64'(exp_pc));
    else                      chk("R3 sequential", 64'(pc), 64'(exp_pc));
  endtask

  function automatic logic [31:0] mk(input int kind, input logic [31:0] body);
    case (kind)
      0: return {body[31:6], 6'h00};
      1: return {body[31:6], 6'h04};
      2: return {body[31:6], 6'h16};
      3: return {body[31:6], 6'h17};
      4: return {body[31:17], 6'h31, body[10:6], 6'h3A};
      5: return {body[31:17], 6'h39, body[10:6], 6'h3A};
      6: return {body[31:17], (body[16:11] == 6'h31 || body[16:11] == 6'h39)
                 ? 6'h00 : body[16:11], body[10:6], 6'h3A};
      default: return body;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; instr = '0; advance = 1'b0; br_taken = 1'b0;
    exp_pc = '0;
    repeat (3) @(posedge clk);
    #1 chk("R1 reset pc", 64'(pc), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 after release", 64'(pc), 64'h0);

    // directed corner cases
    step({16'h0000, 10'd0, 6'h04}, 1'b0, 1'b1);              // R2 hold
    step({5'd1, 5'd2, 16'hFFF0, 6'h16}, 1'b1, 1'b1);         // R4 wrap negative
    step({26'h2AAAAAA, 6'h00}, 1'b1, 1'b0);                  // R6 keeps region
    step({5'd3, 5'd4, 16'h0003, 6'h16}, 1'b1, 1'b1);         // R4 misaligned offset
    step({5'd3, 5'd4, 16'h0040, 6'h16}, 1'b1, 1'b0);         // R4 not taken
    step({5'd1, 5'd2, 5'd3, 6'h31, 5'd0, 6'h3A}, 1'b1, 1'b1);// R5 add with taken
    step({5'd1, 5'd2, 5'd3, 6'h39, 5'd7, 6'h3A}, 1'b1, 1'b0);// R11 subtract
    step({5'd1, 5'd2, 5'd3, 6'h20, 5'd7, 6'h3A}, 1'b1, 1'b1);// R10 bad function
    step({26'h1234567, 6'h3F}, 1'b1, 1'b1);                  // R10 bad opcode
    step({5'd9, 5'd8, 16'h0010, 6'h17}, 1'b1, 1'b1);         // R5 load with taken

    for (int i = 0; i < 3000; i++) begin
      step(mk(int'($urandom % 8), $urandom), ($urandom % 4) != 0, $urandom % 2 == 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule